// File: doc/BRIEF.md
# Program Counter with Rotating Return-Address Stack

This block produces the program address for a small 8-bit processor. It holds eight 14-bit address registers in a push-down file. The entry selected by a 3-bit stack pointer is the live program counter, and the entries below it hold return addresses for nested subroutine calls. A call or a return does not copy addresses between registers. It moves the pointer by one place, and one or two entries are written in the same cycle.

Each cycle the sequencer issues one command:

- hold
- step
- jump
- call
- return
- restart to a fixed vector

A jump, call or return can be made conditional on one of four flag bits, tested either as true or as false. The block reports on its `taken` output whether the last command changed the flow of control. The new program counter and `taken` both appear on the clock edge that accepts the command.

Top module: `pcs_top`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0, `taken` becomes 0 and the stack pointer returns to entry 0.
- R2: Command code 3'b001 (step) adds one to `pc`, wrapping from 14'h3FFF to 14'h0000, and drives `taken` to 0.
- R3: Command code 3'b000 (hold) and the unused codes 3'b110 and 3'b111 leave `pc` and the stored return addresses unchanged and drive `taken` to 0.
- R4: Command code 3'b010 (jump) with `cond_en` low loads `target` into `pc` and drives `taken` to 1.
- R5: Command code 3'b011 (call) with `cond_en` low saves `pc`+1 as the return address and loads `target` into `pc`. Command code 3'b100 (return) with `cond_en` low puts the most recently saved return address back into `pc`. Both drive `taken` to 1.
- R6: Command code 3'b101 (restart) always acts as a taken call to address `rst_num`×8, which is one of 14'h0000, 14'h0008, … 14'h0038, and saves `pc`+1 as the return address.
- R7: When `cond_en` is high, `cond_sel` picks the flag to test: 2'b00 tests `flags[0]` (carry), 2'b01 tests `flags[1]` (zero), 2'b10 tests `flags[2]` (sign) and 2'b11 tests `flags[3]` (parity, where 1 means even).
- R8: With `cond_pol` low, the conditional command is taken when the selected flag is 0. With `cond_pol` high, it is taken when the selected flag is 1.
- R9: A conditional jump, call or return that is not taken advances `pc` by one, drives `taken` to 0, and leaves the stack pointer and the saved return addresses unchanged.
- R10: The stack pointer wraps modulo 8. After eight nested calls, the ninth level overwrites the oldest saved return address, so the eighth return yields that later value and not the original one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Next-address command: 0 hold, 1 step, 2 jump, 3 call, 4 return, 5 restart |
| cond_en | input | 1 | Make the jump, call or return conditional |
| cond_sel | input | 2 | Flag selector for the condition test |
| cond_pol | input | 1 | Test polarity: 1 = taken when the flag is set |
| flags | input | 4 | Flag bits: [0] carry, [1] zero, [2] sign, [3] parity even |
| target | input | 14 | Jump or call destination |
| rst_num | input | 3 | Restart vector number N, giving destination N×8 |
| pc | output | 14 | Current program counter (top of stack) |
| taken | output | 1 | Last command changed the flow of control |

## Verification
Every command is registered once, so its new `pc` and `taken` are due on the first rising edge after the command is presented, and the next command may follow in the very next cycle. The bench drives each command at a falling edge. It then compares `pc` and `taken` against a rotating eight-entry stack model at the following falling edge, which is half a cycle after the one edge that updates them. This keeps each sample in the cycle the result belongs to. The sweeps cover every combination of selector, polarity and flags for conditional jumps, calls and returns. They also cover all eight restart vectors and a nine-level nesting run that exposes the wrap of the stack pointer.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int ADDR_W  = 14;
    localparam int DEPTH   = 8;
    localparam int SP_W    = $clog2(DEPTH);
    localparam int NFLAG   = 4;
    localparam int SEL_W   = $clog2(NFLAG);
    localparam int VEC_W   = 3;
    localparam int VEC_SH  = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SP_W-1:0]   sp_t;

    typedef enum logic [2:0] {
        CMD_HOLD = 3'd0,
        CMD_STEP = 3'd1,
        CMD_JUMP = 3'd2,
        CMD_CALL = 3'd3,
        CMD_RET  = 3'd4,
        CMD_RST  = 3'd5
    } cmd_e;

    // Stack update requested for one cycle
    typedef struct packed {
        logic  wr_cur;   // write entry at sp
        addr_t cur_val;
        logic  wr_nxt;   // write entry at sp+1
        addr_t nxt_val;
        logic  push;     // sp + 1
        logic  pop;      // sp - 1
        logic  taken;
    } upd_t;

    function automatic addr_t vec_addr(logic [VEC_W-1:0] n);
        return addr_t'({n, {VEC_SH{1'b0}}});
    endfunction
endpackage

// File: rtl/pcs_cond.sv
module pcs_cond
    import pcs_pkg::*;
(
    input  logic             cond_en,
    input  logic [SEL_W-1:0] cond_sel,
    input  logic             cond_pol,
    input  logic [NFLAG-1:0] flags,
    output logic             go
);
    logic flag_hit;

    always_comb begin
        flag_hit = flags[cond_sel];
        go = cond_en ? (cond_pol ? flag_hit : ~flag_hit) : 1'b1;
    end
endmodule

// File: rtl/pcs_next.sv
module pcs_next
    import pcs_pkg::*;
(
    input  cmd_e         cmd,
    input  logic         go,
    input  addr_t        pc,
    input  addr_t        target,
    input  logic [VEC_W-1:0] rst_num,
    output upd_t         upd
);
    addr_t pc_inc;

    always_comb begin
        pc_inc = pc + addr_t'(1);
        upd = '0;
        unique case (cmd)
            CMD_STEP: begin
                upd.wr_cur  = 1'b1;
                upd.cur_val = pc_inc;
            end
            CMD_JUMP: begin
                upd.wr_cur  = 1'b1;
                upd.cur_val = go ? target : pc_inc;
                upd.taken   = go;
            end
            CMD_CALL: begin
                upd.wr_cur  = 1'b1;
                upd.cur_val = pc_inc;
                upd.wr_nxt  = go;
                upd.nxt_val = target;
                upd.push    = go;
                upd.taken   = go;
            end
            CMD_RET: begin
                upd.wr_cur  = ~go;
                upd.cur_val = pc_inc;
                upd.pop     = go;
                upd.taken   = go;
            end
            CMD_RST: begin
                upd.wr_cur  = 1'b1;
                upd.cur_val = pc_inc;
                upd.wr_nxt  = 1'b1;
                upd.nxt_val = vec_addr(rst_num);
                upd.push    = 1'b1;
                upd.taken   = 1'b1;
            end
            default: upd = '0;
        endcase
    end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack
    import pcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  upd_t  upd,
    output addr_t top
);
    addr_t ent [DEPTH];
    sp_t   sp;
    sp_t   sp_up;

    assign sp_up = sp + sp_t'(1);
    assign top   = ent[sp];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            if (upd.push)     sp <= sp_up;
            else if (upd.pop) sp <= sp - sp_t'(1);
            for (int i = 0; i < DEPTH; i++) begin
                if (upd.wr_cur && sp == sp_t'(i))
                    ent[i] <= upd.cur_val;
                else if (upd.wr_nxt && sp_up == sp_t'(i))
                    ent[i] <= upd.nxt_val;
            end
        end
    end
endmodule

// File: rtl/pcs_top.sv
module pcs_top
    import pcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cmd,
    input  logic        cond_en,
    input  logic [1:0]  cond_sel,
    input  logic        cond_pol,
    input  logic [3:0]  flags,
    input  logic [13:0] target,
    input  logic [2:0]  rst_num,
    output logic [13:0] pc,
    output logic        taken
);
    logic  go;
    upd_t  upd;
    addr_t top;

    pcs_cond u_cond (
        .cond_en (cond_en),
        .cond_sel(cond_sel),
        .cond_pol(cond_pol),
        .flags   (flags),
        .go      (go)
    );

    pcs_next u_next (
        .cmd    (cmd_e'(cmd)),
        .go     (go),
        .pc     (top),
        .target (target),
        .rst_num(rst_num),
        .upd    (upd)
    );

    pcs_stack u_stack (
        .clk(clk),
        .rst(rst),
        .upd(upd),
        .top(top)
    );

    always_ff @(posedge clk) begin
        if (rst) taken <= 1'b0;
        else     taken <= upd.taken;
    end

    assign pc = top;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  cmd,
    input logic        cond_en,
    input logic [13:0] target,
    input logic [2:0]  rst_num,
    input logic [13:0] pc,
    input logic        taken
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pc == 14'd0 && !taken));

    assert_step_inc_R2: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd1 |=> (pc == $past(pc) + 14'd1 && !taken));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd0 || cmd == 3'd6 || cmd == 3'd7) |=> ($stable(pc) && !taken));

    assert_jump_load_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2 && !cond_en) |=> (taken && pc == $past(target)));

    assert_call_load_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd3 && !cond_en) |=> (taken && pc == $past(target)));

    assert_restart_vec_R6: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd5 |=> (taken && pc == {8'd0, $past(rst_num), 3'd0}));

    assert_not_taken_adv_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2 || cmd == 3'd3 || cmd == 3'd4) |=> (taken || pc == $past(pc) + 14'd1));
endmodule

bind pcs_top pcs_checker u_pcs_checker (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .cond_en(cond_en),
    .target (target),
    .rst_num(rst_num),
    .pc     (pc),
    .taken  (taken)
);

// File: tb/pcs_top_tb.sv
module pcs_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cmd;
    logic        cond_en;
    logic [1:0]  cond_sel;
    logic        cond_pol;
    logic [3:0]  flags;
    logic [13:0] target;
    logic [2:0]  rst_num;
    logic [13:0] pc;
    logic        taken;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [13:0] m_stk [8];
    logic [2:0]  m_sp;

    always #5 clk = ~clk;

    pcs_top dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .cond_en(cond_en), .cond_sel(cond_sel),
        .cond_pol(cond_pol), .flags(flags), .target(target), .rst_num(rst_num),
        .pc(pc), .taken(taken)
    );

    task automatic check(string req, logic [13:0] exp_pc, logic exp_tk);
        n_chk++;
        if (pc !== exp_pc || taken !== exp_tk) begin
            n_bad++;
            $display("FAIL %s: pc=%h taken=%0b expected pc=%h taken=%0b",
                     req, pc, taken, exp_pc, exp_tk);
        end
    endtask

    // Apply one command at a falling edge, update the model, check at next falling edge
    task automatic issue(string req, logic [2:0] c, logic en, logic [1:0] sel,
                         logic pol, logic [3:0] fl, logic [13:0] tg, logic [2:0] vn);
        logic go;
        logic tk;
        logic [13:0] cur;
        cmd = c; cond_en = en; cond_sel = sel; cond_pol = pol;
        flags = fl; target = tg; rst_num = vn;
        go  = !en || (pol ? fl[sel] : !fl[sel]);
        cur = m_stk[m_sp];
        tk  = 1'b0;
        case (c)
            3'd1: m_stk[m_sp] = cur + 14'd1;
            3'd2: begin m_stk[m_sp] = go ? tg : cur + 14'd1; tk = go; end
            3'd3: begin
                m_stk[m_sp] = cur + 14'd1;
                if (go) begin m_sp = m_sp + 3'd1; m_stk[m_sp] = tg; end
                tk = go;
            end
            3'd4: begin
                if (go) m_sp = m_sp - 3'd1;
                else    m_stk[m_sp] = cur + 14'd1;
                tk = go;
            end
            3'd5: begin
                m_stk[m_sp] = cur + 14'd1;
                m_sp = m_sp + 3'd1;
                m_stk[m_sp] = {8'd0, vn, 3'd0};
                tk = 1'b1;
            end
            default: ;
        endcase
        @(negedge clk);
        check(req, m_stk[m_sp], tk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: pc=%h taken=%0b expected completion", pc, taken);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd = 3'd0; cond_en = 1'b0; cond_sel = 2'd0; cond_pol = 1'b0;
        flags = 4'd0; target = 14'd0; rst_num = 3'd0;
        for (int i = 0; i < 8; i++) m_stk[i] = 14'd0;
        m_sp = 3'd0;
        // R1: reset state, after dirtying state first
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        issue("R4 jump", 3'd2, 1'b0, 2'd0, 1'b0, 4'd0, 14'h1234, 3'd0);
        issue("R5 call", 3'd3, 1'b0, 2'd0, 1'b0, 4'd0, 14'h0777, 3'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) m_stk[i] = 14'd0;
        m_sp = 3'd0;
        check("R1 reset", 14'd0, 1'b0);
        // R1: stack pointer back at 0 -> restart then return lands at 1
        issue("R6 restart after reset", 3'd5, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd2);
        issue("R1 return after reset", 3'd4, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);

        // R2: step and wrap
        issue("R2 step", 3'd1, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);
        issue("R4 jump near top", 3'd2, 1'b0, 2'd0, 1'b0, 4'd0, 14'h3FFE, 3'd0);
        issue("R2 step", 3'd1, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);
        issue("R2 step wrap", 3'd1, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);
        issue("R2 step after wrap", 3'd1, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);

        // R3: hold and unused codes, with inputs that would otherwise act
        issue("R3 hold", 3'd0, 1'b0, 2'd0, 1'b0, 4'hF, 14'h2AAA, 3'd7);
        issue("R3 code6", 3'd6, 1'b0, 2'd0, 1'b0, 4'hF, 14'h2AAA, 3'd7);
        issue("R3 code7", 3'd7, 1'b0, 2'd0, 1'b0, 4'hF, 14'h2AAA, 3'd7);
        issue("R3 return after hold", 3'd4, 1'b1, 2'd0, 1'b1, 4'h0, 14'd0, 3'd0);

        // R7 R8 R9: full sweep of conditional jumps
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 2; p++)
                for (int f = 0; f < 16; f++)
                    issue("R7 R8 cond jump", 3'd2, 1'b1, 2'(s), 1'(p), 4'(f),
                          14'(16'h0100 + s * 37 + p * 11 + f), 3'd0);

        // R5 R9: conditional call then conditional return sweep
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 2; p++)
                for (int f = 0; f < 16; f++) begin
                    issue("R9 cond call", 3'd3, 1'b1, 2'(s), 1'(p), 4'(f),
                          14'(16'h2000 + s * 64 + p * 16 + f), 3'd0);
                    issue("R9 cond return", 3'd4, 1'b1, 2'(s), 1'(p), 4'(f), 14'd0, 3'd0);
                    issue("R5 return", 3'd4, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);
                    issue("R5 call", 3'd3, 1'b0, 2'd0, 1'b0, 4'd0, 14'h0400, 3'd0);
                end

        // R6: all restart vectors with return
        for (int v = 0; v < 8; v++) begin
            issue("R6 restart", 3'd5, 1'b0, 2'd0, 1'b0, 4'd0, 14'h3333, 3'(v));
            issue("R6 step in vector", 3'd1, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);
            issue("R6 return", 3'd4, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);
        end

        // R10: nine levels, the oldest return address is overwritten
        issue("R4 jump base", 3'd2, 1'b0, 2'd0, 1'b0, 4'd0, 14'h0050, 3'd0);
        for (int k = 0; k < 8; k++)
            issue("R10 nested call", 3'd3, 1'b0, 2'd0, 1'b0, 4'd0, 14'(16'h1000 + k * 16'h0100), 3'd0);
        for (int k = 0; k < 8; k++)
            issue("R10 nested return", 3'd4, 1'b0, 2'd0, 1'b0, 4'd0, 14'd0, 3'd0);
        n_chk++;
        if (pc !== 14'h1700) begin
            n_bad++;
            $display("FAIL R10 wrap: pc=%h expected %h", pc, 14'h1700);
        end

        cmd = 3'd0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule